// File: doc/BRIEF.md
# Masked-Write Clock Gate Controller

This block holds up to sixteen clock-gate control bits in one 32-bit memory-mapped register, and each bit drives its own glitch-free gated clock. A write does not overwrite the whole register. The upper half of the written word acts as a per-bit write mask for the lower half. Because of this, any number of independent software agents can switch single gates without first reading the register, and no agent disturbs bits that another agent owns.

Each stored bit passes through a polarity stage that is fixed at elaboration. With the default polarity a stored 1 turns the clock on. With the inverted polarity a stored 1 turns it off. The resulting enable feeds a gating cell built from a latch that is open while the source clock is low. An enable that changes during the high phase therefore appears only at the next full clock pulse.

Top module: `hwmask_clk_gate_ctrl`

## Requirements
- R1: On a write (`sel` and `wr_en` both 1 at a rising `clk` edge), each stored gate bit n whose mask bit `wdata[n+16]` is 1 takes the value of `wdata[n]`.
- R2: During that write, each stored gate bit n whose mask bit `wdata[n+16]` is 0 keeps its previous value, whatever `wdata[n]` holds.
- R3: A write whose mask field `wdata[31:16]` is all zero changes neither the stored bits, nor `gate_en`, nor `gclk`.
- R4: `rdata[15:0]` always returns the stored gate bits, with bit n in position n. `rdata[31:16]` always reads zero because the mask is not stored.
- R5: While `rst_n` is 0, the stored bits take the parameter `RESET_VAL`.
- R6: `gate_en[n]` equals stored bit n XOR `INVERT_POL[n]`. A polarity bit of 0 means a stored 1 enables the clock. A polarity bit of 1 means a stored 1 disables it.
- R7: When `sel` or `wr_en` is 0 at a clock edge, the stored bits do not change.
- R8: Every high pulse of `gclk[n]` lasts exactly one full high phase of `clk`. No runt pulse ever appears. After a write at rising edge k, `gclk[n]` pulses at rising edge k+1 and after when `gate_en[n]` is 1, and stays low when it is 0.
- R9: `NUM_GATES` must be between 1 and 16. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock, also the register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Address-decoded register select |
| wr_en | input | 1 | Write strobe, qualified by `sel` |
| wdata | input | 32 | Write word: [31:16] is the mask, [15:0] the values |
| rdata | output | 32 | Read word: stored bits in the low half, zeros in the high half |
| gate_en | output | NUM_GATES | Effective clock enable per gate, after polarity |
| gclk | output | NUM_GATES | Gated clock outputs |

## Verification
On every cycle, the assertions check that masked bits take the write data, that unmasked bits hold their value, that the stored state stays put unless a qualified write occurs, that the upper read half stays zero, and that each enable matches its stored bit under the chosen polarity. Only the bench scenarios show the reset value, the all-zero-mask no-op, and the agreement of long random write sequences with a reference model. The bench also measures the gated clocks: it checks that no pulse is shorter than the source high phase and that each gate pulses exactly when it is enabled.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
   localparam int unsigned REG_W   = 32;
   localparam int unsigned FIELD_W = REG_W / 2;

   typedef logic [FIELD_W-1:0] field_t;

   // merge write data into stored state under a per-bit mask
   function automatic field_t masked_merge(input field_t cur,
                                           input field_t val,
                                           input field_t msk);
      return (cur & ~msk) | (val & msk);
   endfunction
endpackage

// File: rtl/hwm_mask_reg.sv
module hwm_mask_reg
   import hwm_pkg::*;
#(
   parameter int unsigned NUM_GATES = 16,
   parameter logic [NUM_GATES-1:0] RESET_VAL = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_q,
   input  logic [NUM_GATES-1:0] wval,
   input  logic [NUM_GATES-1:0] wmsk,
   output logic [NUM_GATES-1:0] state
);
   logic [NUM_GATES-1:0] nxt;

   always_comb begin
      nxt = state;
      for (int i = 0; i < NUM_GATES; i++) begin
         if (wr_q && wmsk[i]) nxt[i] = wval[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= RESET_VAL;
      else        state <= nxt;
   end

   p_masked_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> ((state & $past(wmsk)) == ($past(wval) & $past(wmsk))));

   p_unmasked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> ((state & ~$past(wmsk)) == ($past(state) & ~$past(wmsk))));

   p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_q |=> $stable(state));
endmodule

// File: rtl/hwm_gate_cell.sv
module hwm_gate_cell (
   input  logic clk_in,
   input  logic en,
   output logic clk_out
);
   logic en_lat;

   // transparent while the source clock is low, closed during the high phase
   always_latch begin
      if (!clk_in) en_lat = en;
   end

   assign clk_out = clk_in & en_lat;
endmodule

// File: rtl/hwmask_clk_gate_ctrl.sv
module hwmask_clk_gate_ctrl
   import hwm_pkg::*;
#(
   parameter int unsigned NUM_GATES = 16,
   parameter logic [NUM_GATES-1:0] RESET_VAL  = '1,
   parameter logic [NUM_GATES-1:0] INVERT_POL = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel,
   input  logic                 wr_en,
   input  logic [REG_W-1:0]     wdata,
   output logic [REG_W-1:0]     rdata,
   output logic [NUM_GATES-1:0] gate_en,
   output logic [NUM_GATES-1:0] gclk
);
   localparam int unsigned MSK_LSB = FIELD_W;

   // R9: the gate field must fit in the low half of the register
   generate
      if (NUM_GATES < 1 || NUM_GATES > FIELD_W) begin : g_bad_cfg
         $error("hwmask_clk_gate_ctrl: NUM_GATES out of range");
      end
   endgenerate

   logic                 wr_q;
   logic [NUM_GATES-1:0] wval;
   logic [NUM_GATES-1:0] wmsk;
   logic [NUM_GATES-1:0] state;

   assign wr_q = sel & wr_en;
   assign wval = wdata[NUM_GATES-1:0];
   assign wmsk = wdata[MSK_LSB +: NUM_GATES];

   hwm_mask_reg #(
      .NUM_GATES (NUM_GATES),
      .RESET_VAL (RESET_VAL)
   ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_q  (wr_q),
      .wval  (wval),
      .wmsk  (wmsk),
      .state (state)
   );

   always_comb begin
      rdata = '0;
      rdata[NUM_GATES-1:0] = state;
   end

   generate
      for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
         if (INVERT_POL[g]) begin : g_inv
            assign gate_en[g] = ~state[g];
         end else begin : g_dir
            assign gate_en[g] = state[g];
         end
         hwm_gate_cell u_cell (
            .clk_in  (clk),
            .en      (gate_en[g]),
            .clk_out (gclk[g])
         );
      end
   endgenerate

   p_upper_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[REG_W-1:MSK_LSB] == '0);

   p_polarity_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en == (rdata[NUM_GATES-1:0] ^ INVERT_POL));
endmodule

// File: tb/hwmask_clk_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hwmask_clk_gate_ctrl_bench;
   localparam int NG = 16;
   localparam logic [NG-1:0] RV  = 16'hA5C3;
   localparam logic [NG-1:0] POL = 16'h00F0;

   typedef struct {
      logic [31:0]   rd;
      logic [NG-1:0] en;
      string         tag;
   } exp_t;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          sel = 0;
   logic          wr_en = 0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NG-1:0] gate_en;
   logic [NG-1:0] gclk;

   int checks = 0;
   int errors = 0;
   exp_t q[$];
   logic [NG-1:0] model;

   always #10 clk = ~clk;

   hwmask_clk_gate_ctrl #(
      .NUM_GATES  (NG),
      .RESET_VAL  (RV),
      .INVERT_POL (POL)
   ) u_hwmask_clk_gate_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .wr_en   (wr_en),
      .wdata   (wdata),
      .rdata   (rdata),
      .gate_en (gate_en),
      .gclk    (gclk)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // driver: one register access, then push the expected port state
   task automatic wr(input logic s, input logic w, input logic [31:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      sel = s; wr_en = w; wdata = d;
      @(posedge clk);
      #1;
      if (s && w) model = (model & ~d[31:16]) | (d[15:0] & d[31:16]);
      e.rd = {16'h0, model};
      e.en = model ^ POL;
      e.tag = tag;
      q.push_back(e);
      sel = 0; wr_en = 0; wdata = '0;
   endtask

   // monitor: compare results on the falling edge after each access
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(rdata == e.rd, {e.tag, " rdata"}, rdata, e.rd);
         check(gate_en == e.en, {e.tag, " gate_en R6"}, {16'h0, gate_en}, {16'h0, e.en});
      end
   end

   // gated clock pulse width monitor (R8): every high pulse must be 10 ns
   logic [NG-1:0] prev_g = '0;
   time rise_t [NG];
   int runts = 0;
   always @(gclk) begin
      for (int i = 0; i < NG; i++) begin
         if (gclk[i] && !prev_g[i]) rise_t[i] = $time;
         else if (!gclk[i] && prev_g[i] && ($time - rise_t[i]) != 10) runts++;
      end
      prev_g = gclk;
   end

   // pulse counter per gate, cleared by the stimulus process
   logic cnt_clr = 1;
   int pcnt [NG];
   always @(posedge clk) begin
      #1;
      for (int i = 0; i < NG; i++) begin
         if (cnt_clr) pcnt[i] = 0;
         else if (gclk[i]) pcnt[i]++;
      end
   end

   initial begin
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      model = RV;
      repeat (3) @(posedge clk);
      #1;
      // R5 / R4 / R6 during and right after reset
      check(rdata == {16'h0, RV}, "R5 reset value", rdata, {16'h0, RV});
      check(gate_en == (RV ^ POL), "R6 reset enables", {16'h0, gate_en}, {16'h0, RV ^ POL});
      @(negedge clk);
      rst_n = 1;

      wr(1, 1, 32'h0008_0008, "R1 set bit3");
      wr(1, 1, 32'h0001_0000, "R1 clear bit0");
      wr(1, 1, 32'h0000_FFFF, "R3 zero mask no-op");
      wr(1, 1, 32'h0030_FFCF, "R2 unmasked data ignored");
      wr(0, 1, 32'hFFFF_FFFF, "R7 no select");
      wr(1, 0, 32'hFFFF_0000, "R7 no write strobe");
      wr(1, 1, 32'hFFFF_0000, "R1 clear all");
      wr(1, 1, 32'hFFFF_FFFF, "R1 set all");
      wr(1, 1, 32'hAAAA_0000, "R2 clear odd bits");

      for (int n = 0; n < 300; n++) begin
         logic [31:0] d;
         d = $urandom;
         if (n % 17 == 0) d[31:16] = '0;
         wr(1, 1, d, "R1 R2 random");
      end

      // R8: known pattern, then count pulses over 20 cycles
      wr(1, 1, 32'hFFFF_0F0F, "R8 pattern A");
      @(negedge clk); cnt_clr = 0;
      repeat (20) @(posedge clk);
      @(negedge clk); cnt_clr = 1;
      for (int i = 0; i < NG; i++) begin
         int exp_p;
         exp_p = gate_en[i] ? 20 : 0;
         check(pcnt[i] == exp_p, "R8 pulse count A", pcnt[i], exp_p);
      end

      // R8: toggle, enables take effect at the next rising edge
      wr(1, 1, 32'hFFFF_F0F0, "R8 pattern B");
      @(negedge clk); cnt_clr = 0;
      repeat (10) @(posedge clk);
      @(negedge clk); cnt_clr = 1;
      for (int i = 0; i < NG; i++) begin
         int exp_p;
         exp_p = gate_en[i] ? 10 : 0;
         check(pcnt[i] == exp_p, "R8 pulse count B", pcnt[i], exp_p);
      end

      // R3 on clocks: zero-mask write keeps pulse pattern
      wr(1, 1, 32'h0000_0F0F, "R3 zero mask keeps clocks");
      @(negedge clk); cnt_clr = 0;
      repeat (5) @(posedge clk);
      @(negedge clk); cnt_clr = 1;
      for (int i = 0; i < NG; i++) begin
         int exp_p;
         exp_p = ((16'hF0F0 ^ POL) >> i) & 1 ? 5 : 0;
         check(pcnt[i] == exp_p, "R3 clocks unchanged", pcnt[i], exp_p);
      end

      repeat (4) @(negedge clk);
      check(q.size() == 0, "scoreboard drained", q.size(), 0);
      check(runts == 0, "R8 no runt pulses", runts, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule